// File: doc/BRIEF.md
# Way-Lockable Instruction Cache

This block sits between an instruction fetch unit and a memory port. Fetch addresses enter a two-entry queue and are served one at a time. A cacheable fetch that hits returns its 32-bit word from a set-associative store. A cacheable fetch that misses starts a whole-line burst. The burst begins at the requested word and wraps through the line. That word reaches the core as soon as it arrives, and the rest of the line is written in behind it.

Software can reserve the lowest-numbered ways of any set by writing a lock count for that set. Replacement cycles round-robin over the remaining ways only. Every stored word keeps the parity bit the memory delivered with it. A hit on a word whose parity no longer matches is handled as a miss, and the same way is refilled. When the cache is disabled, or the fetch is marked non-cacheable, the block reads a single word from memory and allocates nothing.

With the default parameters the store holds 32 sets of 32 ways, with eight words per line. Address bits [4:2] select the word, bits [9:5] select the set and bits [31:10] form the tag.

Top module: `icache_top`

## Requirements
- R1: A cacheable fetch whose set holds a valid line with a matching tag (tag = addr[31:10], set = addr[9:5], word = addr[4:2]) returns the stored word and does not raise mem_req_o.
- R2: A cacheable miss raises mem_req_o with mem_single_o=0 and with mem_addr_o equal to the fetch address with bits [1:0] cleared. The bench's memory returns eight beats in wrap order starting at that word. The requested word appears on rsp_data_o with rsp_valid_o in the cycle after its beat, while later beats are still pending.
- R3: A line becomes valid only once all eight beats are written. A second fetch to the same line, queued behind the miss, is served from the cache with no further memory request.
- R4: Up to two fetches wait in the queue. req_ready_o is low while two are waiting.
- R5: With no ways locked, a set holds WAYS distinct lines. The next miss in that set evicts the oldest-allocated line and leaves the second-oldest resident.
- R6: A write with lock_we_i=1 sets the lock count n of set lock_set_i. Ways 0..n-1 of that set are never chosen as victims, and round-robin continues over ways n..WAYS-1.
- R7: A lock count above 28 is stored as 28.
- R8: Each stored word keeps mem_rpar_i, where correct even parity equals the XOR of the 32 data bits. A hit whose stored parity mismatches invalidates the line, refills it from memory, and returns the correct word.
- R9: A fetch accepted while en_i=0, or with req_cacheable_i=0, is read with mem_single_o=1 as one beat and allocates nothing. A later cacheable fetch to that line misses.
- R10: After reset every line is invalid, all lock counts are 0, req_ready_o=1, rsp_valid_o=0 and mem_req_o=0.
- R11: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_addr_o and mem_single_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Cache enable, sampled when a fetch is accepted |
| req_i | input | 1 | Fetch request |
| req_addr_i | input | 32 | Fetch byte address |
| req_cacheable_i | input | 1 | Cacheable attribute of the fetch |
| req_ready_o | output | 1 | Queue can accept a fetch |
| rsp_valid_o | output | 1 | Instruction word valid (one-cycle pulse) |
| rsp_data_o | output | 32 | Instruction word |
| lock_we_i | input | 1 | Write a lock count |
| lock_set_i | input | 5 | Set whose lock count is written |
| lock_cnt_i | input | 5 | Number of low ways to lock |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Address of the first (critical) word |
| mem_single_o | output | 1 | 1 = one-word read, 0 = eight-word wrapping burst |
| mem_ack_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 32 | Read beat data |
| mem_rpar_i | input | 1 | Read beat parity |

## Verification
The hardest condition to reach is a hit on a word whose stored parity is wrong, because a correct fill always stores good parity. The bench's memory model can be armed to flip the parity bit of one chosen word during one burst. A fetch that misses on a different word of that line loads the corrupted word without touching it. A later fetch of the corrupted word must then trigger exactly one refill and return the right data. Lock behaviour is also hard to expose, since a locked way differs from an unlocked one only after the rest of its set has been cycled through. The bench fills whole sets with more than WAYS lines and then probes which of the original tags still hit.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_MEMREQ, ST_FILL} ic_state_e;

  function automatic logic even_par(logic [31:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/icache_fetch_q.sv
module icache_fetch_q #(
  parameter int W     = 33,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = slot_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/icache_repl.sv
module icache_repl #(
  parameter int SETS     = 32,
  parameter int WAYS     = 32,
  parameter int MAX_LOCK = 28,
  parameter int IDX_W    = $clog2(SETS),
  parameter int WAY_W    = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_we_i,
  input  logic [IDX_W-1:0] lock_set_i,
  input  logic [WAY_W-1:0] lock_cnt_i,
  input  logic [IDX_W-1:0] qset_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [WAY_W-1:0] lock_o
);
  logic [WAY_W-1:0] lock_q [SETS];
  logic [WAY_W-1:0] ptr_q  [SETS];
  logic [WAY_W-1:0] lock_clamped, ptr_cur, victim_nxt;

  assign lock_clamped = (lock_cnt_i > WAY_W'(MAX_LOCK)) ? WAY_W'(MAX_LOCK) : lock_cnt_i;
  assign lock_o       = lock_q[qset_i];
  assign ptr_cur      = ptr_q[qset_i];
  // pointer may lag below a newly raised lock: skip to first unlocked way
  assign victim_o     = (ptr_cur < lock_o) ? lock_o : ptr_cur;
  assign victim_nxt   = (victim_o == WAY_W'(WAYS - 1)) ? lock_o : victim_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        lock_q[s] <= '0;
        ptr_q[s]  <= '0;
      end
    end else begin
      if (lock_we_i) lock_q[lock_set_i] <= lock_clamped;
      if (adv_i)     ptr_q[qset_i]      <= victim_nxt;
    end
  end
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int SETS   = 32,
  parameter int WAYS   = 32,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 22,
  parameter int IDX_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS),
  parameter int WOFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WOFF_W-1:0] word_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [31:0]       rd_data_o,
  output logic              rd_par_ok_o,
  input  logic [WAY_W-1:0]  wway_i,
  input  logic              inv_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic              wr_i,
  input  logic [WOFF_W-1:0] wword_i,
  input  logic [31:0]       wdata_i,
  input  logic              wpar_i,
  input  logic              val_i
);
  import icache_pkg::*;

  localparam int LINES  = SETS * WAYS;
  localparam int LINE_W = $clog2(LINES);

  typedef logic [WORDS-1:0][32:0] line_t;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  line_t            data_q [LINES];
  logic [WAYS-1:0]  match;
  logic [32:0]      entry;
  logic [LINE_W-1:0] widx;

  function automatic logic [LINE_W-1:0] lidx(logic [IDX_W-1:0] s, logic [WAY_W-1:0] w);
    return LINE_W'(s) * LINE_W'(WAYS) + LINE_W'(w);
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lidx(set_i, WAY_W'(w))] && (tag_q[lidx(set_i, WAY_W'(w))] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (match[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o       = |match;
  assign entry       = data_q[lidx(set_i, hit_way_o)][word_i];
  assign rd_data_o   = entry[31:0];
  assign rd_par_ok_o = (even_par(entry[31:0]) == entry[32]);
  assign widx        = lidx(set_i, wway_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (inv_i) valid_q[widx] <= 1'b0;
    else if (val_i) valid_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (inv_i) tag_q[widx] <= wtag_i;
    if (wr_i)  data_q[widx][wword_i] <= {wpar_i, wdata_i};
  end
endmodule

// File: rtl/icache_top.sv
module icache_top #(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 32,
  parameter int WAYS     = 32,
  parameter int WORDS    = 8,
  parameter int MAX_LOCK = 28,
  parameter int QDEPTH   = 2,
  parameter int IDX_W    = $clog2(SETS),
  parameter int WAY_W    = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cacheable_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  input  logic              lock_we_i,
  input  logic [IDX_W-1:0]  lock_set_i,
  input  logic [WAY_W-1:0]  lock_cnt_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_single_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_rpar_i
);
  import icache_pkg::*;

  localparam int BOFF_W = 2;
  localparam int WOFF_W = $clog2(WORDS);
  localparam int WA_W   = ADDR_W - BOFF_W;
  localparam int TAG_W  = WA_W - WOFF_W - IDX_W;

  ic_state_e         state_q;
  logic [WA_W-1:0]   cur_q;
  logic              cur_cach_q, single_q;
  logic [WAY_W-1:0]  way_q;
  logic [WOFF_W-1:0] beat_q, wptr_q;
  logic              rsp_valid_q;
  logic [31:0]       rsp_data_q;

  logic              q_empty, q_full, q_pop, q_push;
  logic [WA_W:0]     q_rdata;
  logic [IDX_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [WOFF_W-1:0] cur_word;
  logic              st_hit, st_par_ok, lookup, good_hit, bad_par, alloc;
  logic [WAY_W-1:0]  st_hit_way, victim, fill_way, lock_cur, wway;
  logic [31:0]       st_rd_data;
  logic              fill_st, first_beat, wr_word, last_beat;

  assign cur_word = cur_q[0 +: WOFF_W];
  assign cur_set  = cur_q[WOFF_W +: IDX_W];
  assign cur_tag  = cur_q[WA_W-1 -: TAG_W];

  assign q_push      = req_i && !q_full;
  assign q_pop       = (state_q == ST_IDLE) && !q_empty;
  assign req_ready_o = !q_full;

  icache_fetch_q #(.W(WA_W + 1), .DEPTH(QDEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .wdata_i ({req_cacheable_i & en_i, req_addr_i[ADDR_W-1:BOFF_W]}),
    .pop_i   (q_pop),
    .rdata_o (q_rdata),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  assign lookup   = (state_q == ST_LOOKUP);
  assign good_hit = lookup && cur_cach_q && st_hit && st_par_ok;
  assign bad_par  = lookup && cur_cach_q && st_hit && !st_par_ok;
  assign alloc    = lookup && cur_cach_q && !st_hit;
  assign fill_way = bad_par ? st_hit_way : victim;
  assign wway     = lookup ? fill_way : way_q;

  assign fill_st    = (state_q == ST_FILL);
  assign first_beat = fill_st && mem_rvalid_i && (beat_q == '0);
  assign last_beat  = (beat_q == WOFF_W'(WORDS - 1));
  assign wr_word    = fill_st && mem_rvalid_i && !single_q;

  icache_repl #(.SETS(SETS), .WAYS(WAYS), .MAX_LOCK(MAX_LOCK), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_repl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_we_i  (lock_we_i),
    .lock_set_i (lock_set_i),
    .lock_cnt_i (lock_cnt_i),
    .qset_i     (cur_set),
    .adv_i      (alloc),
    .victim_o   (victim),
    .lock_o     (lock_cur)
  );

  icache_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(TAG_W),
                 .IDX_W(IDX_W), .WAY_W(WAY_W), .WOFF_W(WOFF_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (cur_set),
    .tag_i       (cur_tag),
    .word_i      (cur_word),
    .hit_o       (st_hit),
    .hit_way_o   (st_hit_way),
    .rd_data_o   (st_rd_data),
    .rd_par_ok_o (st_par_ok),
    .wway_i      (wway),
    .inv_i       (alloc || bad_par),
    .wtag_i      (cur_tag),
    .wr_i        (wr_word),
    .wword_i     (wptr_q),
    .wdata_i     (mem_rdata_i),
    .wpar_i      (mem_rpar_i),
    .val_i       (wr_word && last_beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      cur_cach_q  <= 1'b0;
      single_q    <= 1'b0;
      way_q       <= '0;
      beat_q      <= '0;
      wptr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (q_pop) begin
          cur_q      <= q_rdata[WA_W-1:0];
          cur_cach_q <= q_rdata[WA_W];
          state_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (good_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= st_rd_data;
            state_q     <= ST_IDLE;
          end else begin
            single_q <= !cur_cach_q;
            way_q    <= fill_way;
            state_q  <= ST_MEMREQ;
          end
        end
        ST_MEMREQ: if (mem_ack_i) begin
          beat_q  <= '0;
          wptr_q  <= cur_word;
          state_q <= ST_FILL;
        end
        ST_FILL: if (mem_rvalid_i) begin
          beat_q <= beat_q + 1'b1;
          wptr_q <= wptr_q + 1'b1;
          if (beat_q == '0) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_rdata_i;
          end
          if (single_q || last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign mem_req_o    = (state_q == ST_MEMREQ);
  assign mem_addr_o   = {cur_q, {BOFF_W{1'b0}}};
  assign mem_single_o = single_q;
endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
  parameter int ADDR_W   = 32,
  parameter int WAY_W    = 5,
  parameter int MAX_LOCK = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_single_i,
  input logic              mem_rdata_vld_i,
  input logic [31:0]       mem_rdata_i,
  input logic              rsp_valid_i,
  input logic [31:0]       rsp_data_i,
  input logic              fill_st_i,
  input logic              first_beat_i,
  input logic              alloc_i,
  input logic [WAY_W-1:0]  victim_i,
  input logic [WAY_W-1:0]  lock_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_single_i)); // R11

  AST_CRIT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_beat_i |=> rsp_valid_i && (rsp_data_i == $past(mem_rdata_i))); // R2

  AST_NO_REQ_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_st_i |-> !mem_req_i); // R2

  AST_BEAT_ONLY_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> !mem_rdata_vld_i || !fill_st_i); // R3

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> victim_i >= lock_i); // R6

  AST_LOCK_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> lock_i <= WAY_W'(MAX_LOCK)); // R7
endmodule

bind icache_top icache_checker #(.ADDR_W(ADDR_W), .WAY_W(WAY_W), .MAX_LOCK(MAX_LOCK)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mem_req_i       (mem_req_o),
  .mem_ack_i       (mem_ack_i),
  .mem_addr_i      (mem_addr_o),
  .mem_single_i    (mem_single_o),
  .mem_rdata_vld_i (mem_rvalid_i),
  .mem_rdata_i     (mem_rdata_i),
  .rsp_valid_i     (rsp_valid_o),
  .rsp_data_i      (rsp_data_o),
  .fill_st_i       (fill_st),
  .first_beat_i    (first_beat),
  .alloc_i         (alloc),
  .victim_i        (victim),
  .lock_i          (lock_cur)
);

// File: tb/icache_top_test.sv
`timescale 1ns/1ps
module icache_top_test;
  localparam time TCLK = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_cacheable_i = 1'b1;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        lock_we_i = 1'b0;
  logic [4:0]  lock_set_i = '0;
  logic [4:0]  lock_cnt_i = '0;
  logic        mem_req_o, mem_single_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i, mem_rvalid_i, mem_rpar_i;
  logic [31:0] mem_rdata_i;

  always #(TCLK/2) clk_i = ~clk_i;

  icache_top uut (.*);

  int n_checks = 0, n_fail = 0;
  int n_fill = 0, n_single = 0;
  int beats_left = 0, rsp_beats_left = 0;
  logic [31:0] last_addr = '0;
  logic        last_single = 1'b0;
  logic        mem_hold = 1'b0;
  logic        inj_armed = 1'b0;
  logic [31:0] inj_addr = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] la(int tag, int set, int word);
    return (32'(tag) << 10) | (32'(set) << 5) | (32'(word) << 2);
  endfunction

  task automatic check(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // memory model: wrapping burst from the requested word
  initial begin
    logic [31:0] base, a;
    logic [2:0]  w;
    mem_ack_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0; mem_rpar_i = 0;
    base = '0; w = '0;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 0;
      mem_rvalid_i = 0;
      if (beats_left > 0) begin
        a = {base[31:5], w, 2'b00};
        mem_rvalid_i = 1;
        mem_rdata_i = mem_word(a);
        mem_rpar_i = ^mem_rdata_i;
        if (inj_armed && a == inj_addr) begin
          mem_rpar_i = ~mem_rpar_i;
          inj_armed = 0;
        end
        w = w + 3'd1;
        beats_left--;
      end else if (rst_ni && mem_req_o && !mem_hold) begin
        mem_ack_i = 1;
        base = mem_addr_o;
        w = mem_addr_o[4:2];
        last_addr = mem_addr_o;
        last_single = mem_single_o;
        if (mem_single_o) begin n_single++; beats_left = 1; end
        else begin n_fill++; beats_left = 8; end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && rsp_valid_o) begin
        rsp_beats_left = beats_left;
        if (exp_q.size() == 0) check(0, "unexpected response", rsp_data_o, '0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data_o == e, t, rsp_data_o, e);
        end
      end
    end
  end

  task automatic push(logic [31:0] a, bit c, string r);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_i = 1; req_addr_i = a; req_cacheable_i = c;
    exp_q.push_back(mem_word(a));
    tag_q.push_back(r);
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic settle();
    @(negedge clk_i);
    while (exp_q.size() != 0 || beats_left > 0 || mem_ack_i || mem_req_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic fetch(logic [31:0] a, string r);
    push(a, 1'b1, r);
    settle();
  endtask

  task automatic expect_mem(string r, int f0, int s0, int df, int ds);
    check(n_fill - f0 == df, {r, " fills"}, 32'(n_fill - f0), 32'(df));
    check(n_single - s0 == ds, {r, " singles"}, 32'(n_single - s0), 32'(ds));
  endtask

  task automatic set_lock(int set, int cnt);
    @(negedge clk_i);
    lock_we_i = 1; lock_set_i = 5'(set); lock_cnt_i = 5'(cnt);
    @(negedge clk_i);
    lock_we_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "watchdog", '0, '1);
    finish_run();
  end

  initial begin
    int f0, s0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R10 reset state
    check(req_ready_o == 1, "R10 ready", 32'(req_ready_o), 1);
    check(rsp_valid_o == 0, "R10 rsp_valid", 32'(rsp_valid_o), 0);
    check(mem_req_o == 0, "R10 mem_req", 32'(mem_req_o), 0);

    // R2 miss with critical word first
    f0 = n_fill; s0 = n_single;
    fetch(32'h0000_0014, "R2 critical word");
    expect_mem("R2", f0, s0, 1, 0);
    check(last_addr == 32'h14, "R2 mem addr", last_addr, 32'h14);
    check(last_single == 0, "R2 burst", 32'(last_single), 0);
    check(rsp_beats_left >= 5, "R2 forwarded early", 32'(rsp_beats_left), 5);

    // R1 hits on the filled line
    f0 = n_fill; s0 = n_single;
    fetch(32'h0000_0000, "R1 hit w0");
    fetch(32'h0000_001C, "R1 hit w7");
    expect_mem("R1", f0, s0, 0, 0);

    // R3 back-to-back to same line: one fill
    f0 = n_fill; s0 = n_single;
    push(la(2, 2, 6), 1, "R3 miss");
    push(la(2, 2, 1), 1, "R3 follower");
    settle();
    expect_mem("R3", f0, s0, 1, 0);

    // R9 bypass and no allocation
    f0 = n_fill; s0 = n_single;
    push(la(3, 4, 2), 0, "R9 noncacheable");
    settle();
    expect_mem("R9 nc", f0, s0, 0, 1);
    check(last_single == 1, "R9 single flag", 32'(last_single), 1);
    f0 = n_fill; s0 = n_single;
    fetch(la(3, 4, 2), "R9 later miss");
    expect_mem("R9 no alloc", f0, s0, 1, 0);
    en_i = 0;
    f0 = n_fill; s0 = n_single;
    fetch(la(5, 4, 0), "R9 disabled");
    expect_mem("R9 disabled", f0, s0, 0, 1);
    en_i = 1;
    f0 = n_fill; s0 = n_single;
    fetch(la(5, 4, 0), "R9 after enable");
    expect_mem("R9 after enable", f0, s0, 1, 0);

    // R4 queue depth, R11 request hold
    mem_hold = 1;
    f0 = n_fill; s0 = n_single;
    push(la(1, 3, 0), 1, "R4 A");
    push(la(1, 3, 1), 1, "R4 B");
    push(la(2, 3, 0), 1, "R4 C");
    @(negedge clk_i);
    check(req_ready_o == 0, "R4 queue full", 32'(req_ready_o), 0);
    check(mem_req_o == 1 && mem_addr_o == la(1, 3, 0), "R11 request up", mem_addr_o, la(1, 3, 0));
    repeat (5) @(negedge clk_i);
    check(mem_req_o == 1 && mem_addr_o == la(1, 3, 0), "R11 request held", mem_addr_o, la(1, 3, 0));
    mem_hold = 0;
    settle();
    expect_mem("R4", f0, s0, 2, 0);

    // R5 round robin with no locks, set 6
    for (int k = 1; k <= 32; k++) fetch(la(k, 6, 0), "R5 fill");
    f0 = n_fill; s0 = n_single;
    for (int k = 1; k <= 32; k++) fetch(la(k, 6, 3), "R5 resident");
    expect_mem("R5 all resident", f0, s0, 0, 0);
    fetch(la(33, 6, 0), "R5 evict");
    f0 = n_fill; s0 = n_single;
    fetch(la(2, 6, 0), "R5 second oldest");
    expect_mem("R5 second oldest hits", f0, s0, 0, 0);
    f0 = n_fill; s0 = n_single;
    fetch(la(1, 6, 0), "R5 oldest");
    expect_mem("R5 oldest evicted", f0, s0, 1, 0);

    // R6 locking two ways of set 5
    for (int k = 1; k <= 4; k++) fetch(la(k, 5, 0), "R6 fill");
    set_lock(5, 2);
    for (int k = 10; k < 40; k++) fetch(la(k, 5, 0), "R6 churn");
    f0 = n_fill; s0 = n_single;
    fetch(la(1, 5, 2), "R6 locked w0");
    fetch(la(2, 5, 2), "R6 locked w1");
    expect_mem("R6 locked resident", f0, s0, 0, 0);
    f0 = n_fill; s0 = n_single;
    fetch(la(3, 5, 2), "R6 unlocked evicted");
    expect_mem("R6 unlocked evicted", f0, s0, 1, 0);

    // R7 clamp on set 7
    for (int k = 1; k <= 32; k++) fetch(la(k, 7, 0), "R7 fill");
    set_lock(7, 31);
    for (int k = 40; k < 44; k++) fetch(la(k, 7, 0), "R7 churn");
    f0 = n_fill; s0 = n_single;
    for (int k = 1; k <= 28; k++) fetch(la(k, 7, 1), "R7 locked");
    expect_mem("R7 locked resident", f0, s0, 0, 0);
    f0 = n_fill; s0 = n_single;
    fetch(la(29, 7, 1), "R7 way 28 replaceable");
    expect_mem("R7 clamp", f0, s0, 1, 0);

    // R8 parity error on a hit
    inj_addr = la(1, 8, 3);
    inj_armed = 1;
    fetch(la(1, 8, 0), "R8 fill");
    f0 = n_fill; s0 = n_single;
    fetch(la(1, 8, 3), "R8 bad parity word");
    expect_mem("R8 refetch", f0, s0, 1, 0);
    f0 = n_fill; s0 = n_single;
    fetch(la(1, 8, 3), "R8 repaired");
    fetch(la(1, 8, 5), "R8 line valid");
    expect_mem("R8 repaired hit", f0, s0, 0, 0);

    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule